// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

This block buffers 36-bit words in a single clock domain behind a parameterised storage array. The read side works in one of two modes, latched when master reset is applied. In standard mode a word appears on the read data output on the clock edge that follows a read request. In fall-through mode the oldest word is moved to the output register without any request, and a read request moves the next one in.

Two status outputs change meaning with the mode. In standard mode they are an empty indication (low when nothing can be read) and a full indication (low when nothing can be written). In fall-through mode they are an output-valid signal and a space-available signal. A half-full flag and two programmable threshold flags, both active low, report the number of words held in the storage array. The two threshold offsets come from configuration inputs that are captured at master reset. A partial reset empties the buffer but keeps the captured mode and offsets. A retransmit request rewinds only the read side to location zero, so data already written can be read out again.

Top module: `fifo_dual_mode`

## Requirements
- R1: While `mstr_rst` is high at a clock edge, both pointers clear, `rd_data` becomes 0, and the mode and both offsets are taken from `cfg_fwft`, `cfg_ae_off` and `cfg_af_off`. After the edge, `st_avail` is 0, `st_space` is 1 and `half_full` is 0.
- R2: In standard mode (`cfg_fwft`=0 at master reset), a high `rd_en` on a non-empty buffer puts the oldest word on `rd_data` after that clock edge. Words leave in the order they were written. `st_avail` is high exactly when a word can be read.
- R3: In fall-through mode (`cfg_fwft`=1), the oldest stored word is loaded into `rd_data` with no request, and `st_avail` rises on the same edge. A write to an empty buffer is visible two edges after the write. Each `rd_en` with `st_avail` high replaces the word, or drops `st_avail` when nothing is stored. With no request, the word and `st_avail` hold.
- R4: The array holds DEPTH words. When it is full, `st_space` is low and a write is ignored.
- R5: A read request while nothing can be read is ignored, and `rd_data` keeps its value.
- R6: `half_full` is high exactly when the stored word count exceeds DEPTH/2.
- R7: `almost_empty_n` is low when the stored count is below the empty offset, and high when it is at or above it.
- R8: `almost_full_n` is high when the free locations (DEPTH minus stored count) exceed the full offset, and low when they are at or below it.
- R9: `part_rst` clears both pointers and `rd_data`, but keeps the mode and offsets captured at the last master reset, whatever the configuration inputs are.
- R10: A high `rexmit` at a clock edge moves the read pointer to location zero and leaves the write pointer alone. For the cycle that follows, `st_avail` is low and read requests are ignored. Reading then restarts from the first word written since reset.
- R11: In standard mode, a simultaneous write and read on a buffer that is neither empty nor full leaves the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mstr_rst | input | 1 | Synchronous master reset, active high; captures the configuration |
| part_rst | input | 1 | Synchronous partial reset, active high; keeps the configuration |
| cfg_fwft | input | 1 | Read mode sampled at master reset: 0 standard, 1 fall-through |
| cfg_ae_off | input | CW | Almost-empty offset sampled at master reset |
| cfg_af_off | input | CW | Almost-full offset sampled at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rexmit | input | 1 | Rewind the read pointer to location zero |
| rd_data | output | WIDTH | Registered read data |
| st_avail | output | 1 | Standard: not-empty flag; fall-through: output word valid |
| st_space | output | 1 | Standard: not-full flag; fall-through: input ready |
| half_full | output | 1 | Stored count above DEPTH/2 |
| almost_empty_n | output | 1 | Low while stored count is below the empty offset |
| almost_full_n | output | 1 | Low while free locations are at or below the full offset |

## Verification
The bound checker enforces these rules on every cycle. A write into a full array leaves it full. A standard-mode read with nothing available leaves the output unchanged. A standard-mode read and write together keep the count. A retransmit blanks `st_avail` for one cycle. A valid fall-through word stays put until it is read. Word ordering, the exact boundaries of the half-full and threshold flags, and the two-edge fall-through latency all need directed scenarios. So do partial reset keeping the old configuration while the inputs change, and the replay of earlier words after a rewind.

// File: rtl/fifo_dm_pkg.sv
package fifo_dm_pkg;

    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/fifo_dm_store.sv
module fifo_dm_store #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fifo_dm_flags.sv
module fifo_dm_flags #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] fill,
    input  logic          fwft,
    input  logic          head_valid,
    input  logic          rewind_hold,
    input  logic [CW-1:0] ae_off,
    input  logic [CW-1:0] af_off,
    output logic          st_avail,
    output logic          st_space,
    output logic          half_full,
    output logic          almost_empty_n,
    output logic          almost_full_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic          is_empty;
    logic          is_full;
    logic [CW-1:0] free_cnt;

    always_comb begin
        is_empty       = (fill == '0);
        is_full        = (fill == FULL_CNT);
        free_cnt       = FULL_CNT - fill;
        st_avail       = fwft ? head_valid : (!is_empty && !rewind_hold);
        st_space       = !is_full;
        half_full      = (fill > HALF_CNT);
        almost_empty_n = (fill >= ae_off);
        almost_full_n  = (free_cnt > af_off);
    end

endmodule

// File: rtl/fifo_dm_ctrl.sv
module fifo_dm_ctrl
    import fifo_dm_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             mstr_rst,
    input  logic             part_rst,
    input  logic             cfg_fwft,
    input  logic [CW-1:0]    cfg_ae_off,
    input  logic [CW-1:0]    cfg_af_off,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             rexmit,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [AW-1:0]    mem_raddr,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill,
    output logic             fwft,
    output logic             head_valid,
    output logic             rewind_hold,
    output logic [CW-1:0]    ae_off,
    output logic [CW-1:0]    af_off
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0]    wptr;
        logic [CW-1:0]    rptr;
        logic [WIDTH-1:0] dout;
        logic             valid;
        logic             hold;
        rd_mode_e         mode;
        logic [CW-1:0]    ae_off;
        logic [CW-1:0]    af_off;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;
    logic [CW-1:0] fill_c;
    logic          empty_c;
    logic          full_c;
    logic          push_c;

    always_comb begin
        fill_c  = st_q.wptr - st_q.rptr;
        empty_c = (fill_c == '0);
        full_c  = (fill_c == FULL_CNT);
        push_c  = wr_en && !full_c && !mstr_rst && !part_rst;
        st_d    = st_q;

        if (mstr_rst) begin
            st_d        = '0;
            st_d.mode   = cfg_fwft ? RD_FALLTHRU : RD_STANDARD;
            st_d.ae_off = cfg_ae_off;
            st_d.af_off = cfg_af_off;
        end else if (part_rst) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.dout  = '0;
            st_d.valid = 1'b0;
            st_d.hold  = 1'b0;
        end else begin
            if (push_c) begin
                st_d.wptr = st_q.wptr + ONE;
            end
            if (rexmit) begin
                st_d.rptr = '0;
                st_d.hold = 1'b1;
                if (st_q.mode == RD_FALLTHRU) begin
                    st_d.valid = 1'b0;
                end
            end else begin
                st_d.hold = 1'b0;
                if (!st_q.hold) begin
                    if (st_q.mode == RD_STANDARD) begin
                        if (rd_en && !empty_c) begin
                            st_d.dout = mem_rdata;
                            st_d.rptr = st_q.rptr + ONE;
                        end
                    end else begin
                        if ((!st_q.valid || rd_en) && !empty_c) begin
                            st_d.dout  = mem_rdata;
                            st_d.rptr  = st_q.rptr + ONE;
                            st_d.valid = 1'b1;
                        end else if (rd_en && st_q.valid) begin
                            st_d.valid = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we      = push_c;
    assign mem_waddr   = st_q.wptr[AW-1:0];
    assign mem_raddr   = st_q.rptr[AW-1:0];
    assign rd_data     = st_q.dout;
    assign fill        = fill_c;
    assign fwft        = (st_q.mode == RD_FALLTHRU);
    assign head_valid  = st_q.valid;
    assign rewind_hold = st_q.hold;
    assign ae_off      = st_q.ae_off;
    assign af_off      = st_q.af_off;

endmodule

// File: rtl/fifo_dual_mode.sv
module fifo_dual_mode #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             mstr_rst,
    input  logic             part_rst,
    input  logic             cfg_fwft,
    input  logic [CW-1:0]    cfg_ae_off,
    input  logic [CW-1:0]    cfg_af_off,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rexmit,
    output logic [WIDTH-1:0] rd_data,
    output logic             st_avail,
    output logic             st_space,
    output logic             half_full,
    output logic             almost_empty_n,
    output logic             almost_full_n
);

    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [AW-1:0]    mem_raddr;
    logic [WIDTH-1:0] mem_rdata;
    logic [CW-1:0]    fill;
    logic             fwft;
    logic             head_valid;
    logic             rewind_hold;
    logic [CW-1:0]    ae_off;
    logic [CW-1:0]    af_off;

    fifo_dm_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    fifo_dm_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .mstr_rst    (mstr_rst),
        .part_rst    (part_rst),
        .cfg_fwft    (cfg_fwft),
        .cfg_ae_off  (cfg_ae_off),
        .cfg_af_off  (cfg_af_off),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .rexmit      (rexmit),
        .mem_rdata   (mem_rdata),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_raddr   (mem_raddr),
        .rd_data     (rd_data),
        .fill        (fill),
        .fwft        (fwft),
        .head_valid  (head_valid),
        .rewind_hold (rewind_hold),
        .ae_off      (ae_off),
        .af_off      (af_off)
    );

    fifo_dm_flags #(.DEPTH(DEPTH)) u_flags (
        .fill           (fill),
        .fwft           (fwft),
        .head_valid     (head_valid),
        .rewind_hold    (rewind_hold),
        .ae_off         (ae_off),
        .af_off         (af_off),
        .st_avail       (st_avail),
        .st_space       (st_space),
        .half_full      (half_full),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

endmodule

// File: rtl/fifo_dual_mode_chk.sv
module fifo_dual_mode_chk #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             mstr_rst,
    input logic             part_rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rexmit,
    input logic [WIDTH-1:0] rd_data,
    input logic             st_avail,
    input logic             st_space,
    input logic             fwft,
    input logic [CW-1:0]    fill
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R4: a write into a full array leaves it full
    p_full_write_ignored_r4: assert property (@(posedge clk) disable iff (mstr_rst || part_rst)
        (!st_space && wr_en && !rd_en && !rexmit) |=> (fill == FULL_CNT));

    // R5: a standard-mode read with nothing available leaves the output alone
    p_empty_read_ignored_r5: assert property (@(posedge clk) disable iff (mstr_rst || part_rst)
        (!fwft && !st_avail && rd_en && !rexmit) |=> $stable(rd_data));

    // R11: concurrent read and write keep the count in standard mode
    p_rw_keeps_fill_r11: assert property (@(posedge clk) disable iff (mstr_rst || part_rst)
        (!fwft && st_avail && st_space && wr_en && rd_en && !rexmit) |=> $stable(fill));

    // R10: rewind blanks the read-side status for one cycle
    p_rewind_blank_r10: assert property (@(posedge clk) disable iff (mstr_rst || part_rst)
        rexmit |=> !st_avail);

    // R3: a presented fall-through word holds until read
    p_head_holds_r3: assert property (@(posedge clk) disable iff (mstr_rst || part_rst)
        (fwft && st_avail && !rd_en && !rexmit) |=> (st_avail && $stable(rd_data)));

endmodule

bind fifo_dual_mode fifo_dual_mode_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .mstr_rst (mstr_rst),
    .part_rst (part_rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rexmit   (rexmit),
    .rd_data  (rd_data),
    .st_avail (st_avail),
    .st_space (st_space),
    .fwft     (fwft),
    .fill     (fill)
);

// File: tb/tb_fifo_dual_mode.sv
module tb_fifo_dual_mode;

    localparam int WIDTH = 36;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             mstr_rst = 1'b1;
    logic             part_rst = 1'b0;
    logic             cfg_fwft = 1'b0;
    logic [CW-1:0]    cfg_ae_off = '0;
    logic [CW-1:0]    cfg_af_off = '0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic             rexmit = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             st_avail;
    logic             st_space;
    logic             half_full;
    logic             almost_empty_n;
    logic             almost_full_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    fifo_dual_mode #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk(clk), .mstr_rst(mstr_rst), .part_rst(part_rst), .cfg_fwft(cfg_fwft),
        .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rexmit(rexmit), .rd_data(rd_data), .st_avail(st_avail),
        .st_space(st_space), .half_full(half_full), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    function automatic logic [WIDTH-1:0] word(input int i);
        return WIDTH'(36'h9_A500_0000) + WIDTH'(i * 3 + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic mreset(input logic fw, input int ae, input int af);
        cfg_fwft   = fw;
        cfg_ae_off = CW'(ae);
        cfg_af_off = CW'(af);
        mstr_rst   = 1'b1;
        step();
        mstr_rst   = 1'b0;
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        mreset(1'b0, 3, 2);
        chk(st_avail == 1'b0, "R1 avail", WIDTH'(st_avail), 0);
        chk(st_space == 1'b1, "R1 space", WIDTH'(st_space), 1);
        chk(half_full == 1'b0, "R1 half", WIDTH'(half_full), 0);
        chk(almost_empty_n == 1'b0, "R1 ae", WIDTH'(almost_empty_n), 0);
        chk(almost_full_n == 1'b1, "R1 af", WIDTH'(almost_full_n), 1);
        chk(rd_data == '0, "R1 data", rd_data, 0);
    endtask

    task automatic t_standard();
        mreset(1'b0, 3, 2);
        for (int i = 0; i < 5; i++) begin
            push(word(i));
            if (i == 0) chk(st_avail == 1'b1, "R2 avail", WIDTH'(st_avail), 1);
            if (i == 1) chk(almost_empty_n == 1'b0, "R7 below", WIDTH'(almost_empty_n), 0);
            if (i == 2) chk(almost_empty_n == 1'b1, "R7 at", WIDTH'(almost_empty_n), 1);
        end
        for (int i = 0; i < 5; i++) begin
            pop();
            chk(rd_data == word(i), "R2 order", rd_data, word(i));
            if (i == 2) chk(almost_empty_n == 1'b0, "R7 drain", WIDTH'(almost_empty_n), 0);
        end
        chk(st_avail == 1'b0, "R2 empty", WIDTH'(st_avail), 0);
        pop();
        chk(rd_data == word(4), "R5 ignored", rd_data, word(4));
    endtask

    task automatic t_full();
        mreset(1'b0, 3, 2);
        chk(rd_data == '0, "R1 clear", rd_data, 0);
        for (int i = 1; i <= DEPTH; i++) begin
            push(word(i));
            if (i == 8)  chk(half_full == 1'b0, "R6 at half", WIDTH'(half_full), 0);
            if (i == 9)  chk(half_full == 1'b1, "R6 over", WIDTH'(half_full), 1);
            if (i == 13) chk(almost_full_n == 1'b1, "R8 free3", WIDTH'(almost_full_n), 1);
            if (i == 14) chk(almost_full_n == 1'b0, "R8 free2", WIDTH'(almost_full_n), 0);
        end
        chk(st_space == 1'b0, "R4 full", WIDTH'(st_space), 0);
        push(WIDTH'(36'h0_DEAD_BEEF));
        chk(st_space == 1'b0, "R4 still full", WIDTH'(st_space), 0);
        for (int i = 1; i <= DEPTH; i++) begin
            pop();
            chk(rd_data == word(i), "R4 contents", rd_data, word(i));
        end
        chk(st_avail == 1'b0, "R4 extra dropped", WIDTH'(st_avail), 0);
    endtask

    task automatic t_simul();
        mreset(1'b0, 4, 11);
        for (int i = 0; i < 4; i++) push(word(i));
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; wr_data = word(i + 4); rd_en = 1'b1;
            step();
            wr_en = 1'b0; rd_en = 1'b0;
            chk(rd_data == word(i), "R11 data", rd_data, word(i));
            chk(almost_empty_n == 1'b1, "R11 no drop", WIDTH'(almost_empty_n), 1);
            chk(almost_full_n == 1'b1, "R11 no rise", WIDTH'(almost_full_n), 1);
        end
        for (int i = 3; i < 7; i++) begin
            pop();
            chk(rd_data == word(i), "R11 drain", rd_data, word(i));
        end
        chk(st_avail == 1'b0, "R11 empty", WIDTH'(st_avail), 0);
    endtask

    task automatic t_rewind();
        mreset(1'b0, 3, 2);
        for (int i = 0; i < 3; i++) push(word(i + 20));
        pop(); pop();
        chk(rd_data == word(21), "R10 pre", rd_data, word(21));
        rexmit = 1'b1;
        step();
        rexmit = 1'b0;
        chk(st_avail == 1'b0, "R10 blank", WIDTH'(st_avail), 0);
        step();
        chk(st_avail == 1'b1, "R10 back", WIDTH'(st_avail), 1);
        push(word(23));
        for (int i = 0; i < 4; i++) begin
            pop();
            chk(rd_data == word(i + 20), "R10 replay", rd_data, word(i + 20));
        end
        chk(st_avail == 1'b0, "R10 end", WIDTH'(st_avail), 0);
    endtask

    task automatic t_fallthru();
        mreset(1'b1, 3, 2);
        chk(st_avail == 1'b0, "R1 fwft avail", WIDTH'(st_avail), 0);
        push(word(40));
        chk(st_avail == 1'b0, "R3 not yet", WIDTH'(st_avail), 0);
        step();
        chk(st_avail == 1'b1, "R3 ready", WIDTH'(st_avail), 1);
        chk(rd_data == word(40), "R3 first", rd_data, word(40));
        push(word(41)); push(word(42));
        chk(rd_data == word(40), "R3 hold", rd_data, word(40));
        pop();
        chk(rd_data == word(41), "R3 next", rd_data, word(41));
        pop();
        chk(rd_data == word(42), "R3 last", rd_data, word(42));
        pop();
        chk(st_avail == 1'b0, "R3 drained", WIDTH'(st_avail), 0);
    endtask

    task automatic t_partial();
        mreset(1'b1, 5, 3);
        for (int i = 0; i < 3; i++) push(word(i + 60));
        step();
        cfg_fwft = 1'b0; cfg_ae_off = '0; cfg_af_off = '0;
        part_rst = 1'b1;
        step();
        part_rst = 1'b0;
        chk(rd_data == '0, "R9 data", rd_data, 0);
        chk(st_avail == 1'b0, "R9 avail", WIDTH'(st_avail), 0);
        chk(almost_empty_n == 1'b0, "R9 offset kept", WIDTH'(almost_empty_n), 0);
        push(word(70));
        step();
        chk(st_avail == 1'b1, "R9 mode kept", WIDTH'(st_avail), 1);
        chk(rd_data == word(70), "R9 word", rd_data, word(70));
        pop();
        chk(st_avail == 1'b0, "R9 ptr cleared", WIDTH'(st_avail), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        step();
        t_reset();
        t_standard();
        t_full();
        t_simul();
        t_rewind();
        t_fallthru();
        t_partial();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule